// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects up to eight interrupt requests, ranks them in fixed priority order (level 0 highest, level 7 lowest) and raises one interrupt line toward a processor. When the processor acknowledges, the block returns an 8-bit vector and marks the winning level as in service. That level stays in service until software ends it with an end-of-interrupt command. While a level is in service, requests of the same or lower priority wait. A request of higher priority can still interrupt, which gives fully nested service.

Software reaches the block through a byte-wide write port with a single address bit. A command word written to the even address with data bit 4 set starts an initialization sequence. Further words written to the odd address then complete the sequence in a fixed order. After initialization, software can change the mask, issue end-of-interrupt commands and choose which register is read back. The request inputs can latch on rising edges or follow the input level. A flag on the ports shows whether the block was set up for use in a cascade.

Top module: `pvic_top`

## Requirements
- R1: Until the initialization sequence completes, int_o stays 0 and even-address words with data bit 4 clear are ignored.
- R2: An even-address write with bit 4 set starts a new sequence. In that first word, bit 3 selects level triggering, bit 1 selects single mode and bit 0 says a fourth word follows. The next odd-address writes are then taken in order: the vector-base word, a cascade word only when bit 1 was 0, and the fourth word only when bit 0 was 1. cascade_o is 1 only after a completed sequence with bit 1 equal to 0.
- R3: After initialization, every odd-address write loads the mask. A set mask bit stops its level from raising int_o, but the request is still recorded. A read at the odd address returns the mask.
- R4: int_o is 1 when an unmasked request is pending and its level number is lower than that of every in-service level.
- R5: In level mode, the request register follows the inputs, so a request that goes low is withdrawn.
- R6: A one-cycle inta_i pulse makes vector_vld_o go to 1 on the next cycle. vector_o then equals data bits 7..3 of the vector-base word followed by the 3-bit number of the winning level, and that level moves from the request register to the in-service register. With no winner, the level field reads 7 and nothing changes.
- R7: An even-address word with bits 4 and 3 clear and bits 7..5 equal to 001 clears the highest-priority in-service bit.
- R8: An even-address word with bits 4 and 3 clear and bits 7..5 equal to 011 clears the in-service bit given by bits 2..0.
- R9: In edge mode, an input that stays high after being acknowledged is not latched again until it has gone low and risen again.
- R10: An even-address word with bit 4 clear and bit 3 set selects the even-address read. With bit 1 set, bit 0 picks in-service (1) or request (0). A new initialization sequence clears the mask, the in-service register and the request register, and selects the request register for reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data: mask at the odd address; request or in-service register at the even address |
| irq_i | input | 8 | Request inputs, index 0 has the highest priority |
| int_o | output | 1 | Interrupt line to the processor |
| inta_i | input | 1 | Acknowledge pulse |
| vector_o | output | 8 | Vector from the last acknowledge |
| vector_vld_o | output | 1 | Vector valid, one cycle after an acknowledge |
| cascade_o | output | 1 | Set up for cascade operation |

## Verification
Each of the three registers has its own way of showing up at the ports when it holds a wrong value. A stale or lost in-service bit changes int_o on the first cycle after the event: a lower-priority request that should wait gets through, or a higher-priority one is blocked. An error in the request register appears in the very next even-address read and in the level field of the following vector. A mistake in decoding the sequence shows up as a wrong vector base, a wrong cascade flag or a wrong mask right after the last word is written. For these reasons the sweep checks int_o, the read-back registers and the vector on the first cycle after every stimulus.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_READY
  } init_st_e;

  typedef struct packed {
    logic       ns;
    logic       sp;
    logic [2:0] lvl;
  } eoi_cmd_t;
endpackage

// File: rtl/pvic_cmd_dec.sv
module pvic_cmd_dec
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned LVL_W  = $clog2(NUM_IRQ),
  localparam int unsigned BASE_W = DATA_W - LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ready_o,
  output logic               ltim_o,
  output logic               single_o,
  output logic [BASE_W-1:0]  base_o,
  output logic [NUM_IRQ-1:0] imr_o,
  output logic               rd_isr_o,
  output logic               start_o,
  output eoi_cmd_t           eoi_o
);
  init_st_e st_q;
  logic need_mode_q;
  logic even_wr, odd_wr, ctl_wr;

  assign even_wr = wr_i && !addr_i;
  assign odd_wr  = wr_i && addr_i;
  assign start_o = even_wr && wdata_i[4];
  assign ready_o = (st_q == ST_READY);
  assign ctl_wr  = even_wr && !wdata_i[4] && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_UNINIT;
      need_mode_q <= 1'b0;
      ltim_o      <= 1'b0;
      single_o    <= 1'b1;
      base_o      <= '0;
      imr_o       <= '0;
      rd_isr_o    <= 1'b0;
    end else if (start_o) begin
      st_q        <= ST_BASE;
      ltim_o      <= wdata_i[3];
      single_o    <= wdata_i[1];
      need_mode_q <= wdata_i[0];
      imr_o       <= '0;
      rd_isr_o    <= 1'b0;
    end else if (odd_wr) begin
      unique case (st_q)
        ST_BASE: begin
          base_o <= wdata_i[DATA_W-1:LVL_W];
          if (!single_o)        st_q <= ST_CASC;
          else if (need_mode_q) st_q <= ST_MODE;
          else                  st_q <= ST_READY;
        end
        ST_CASC:  st_q <= need_mode_q ? ST_MODE : ST_READY;
        ST_MODE:  st_q <= ST_READY;
        ST_READY: imr_o <= wdata_i[NUM_IRQ-1:0];
        default:  st_q <= st_q;
      endcase
    end else if (ctl_wr && wdata_i[3] && wdata_i[1]) begin
      rd_isr_o <= wdata_i[0];
    end
  end

  always_comb begin
    eoi_o     = '0;
    eoi_o.lvl = wdata_i[2:0];
    if (ctl_wr && !wdata_i[3]) begin
      eoi_o.ns = (wdata_i[7:5] == 3'b001);
      eoi_o.sp = (wdata_i[7:5] == 3'b011);
    end
  end
endmodule

// File: rtl/pvic_req.sv
module pvic_req #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               ltim_i,
  input  logic               clr_i,
  input  logic [NUM_IRQ-1:0] ack_oh_i,
  output logic [NUM_IRQ-1:0] irr_o
);
  logic [NUM_IRQ-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    logic rise;
    assign rise = irq_i[i] && !irq_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          irr_o[i] <= 1'b0;
      else if (clr_i)       irr_o[i] <= 1'b0;
      else if (ack_oh_i[i]) irr_o[i] <= 1'b0;
      else if (ltim_i)      irr_o[i] <= irq_i[i];
      else if (rise)        irr_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/pvic_prio.sv
module pvic_prio #(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned LVL_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] vec_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   idx_o,
  output logic [NUM_IRQ-1:0] oh_o
);
  assign any_o = |vec_i;
  assign oh_o  = vec_i & (~vec_i + NUM_IRQ'(1));

  always_comb begin
    idx_o = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = LVL_W'(i);
    end
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned LVL_W  = $clog2(NUM_IRQ),
  localparam int unsigned BASE_W = DATA_W - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic              int_o,
  input  logic              inta_i,
  output logic [DATA_W-1:0] vector_o,
  output logic              vector_vld_o,
  output logic              cascade_o
);
  logic               ready, ltim, single, rd_isr, start;
  logic [BASE_W-1:0]  base;
  logic [NUM_IRQ-1:0] imr, irr, isr_q, isr_d, pend, win_oh, isr_oh, ack_oh;
  logic               pend_any, isr_any, grant;
  logic [LVL_W-1:0]   win_idx, isr_idx;
  eoi_cmd_t           eoi;

  pvic_cmd_dec #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) i_dec (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .ready_o(ready), .ltim_o(ltim), .single_o(single), .base_o(base),
    .imr_o(imr), .rd_isr_o(rd_isr), .start_o(start), .eoi_o(eoi)
  );

  pvic_req #(.NUM_IRQ(NUM_IRQ)) i_req (
    .clk_i, .rst_ni, .irq_i, .ltim_i(ltim), .clr_i(start),
    .ack_oh_i(ack_oh), .irr_o(irr)
  );

  assign pend = irr & ~imr;

  pvic_prio #(.NUM_IRQ(NUM_IRQ)) i_prio_req (
    .vec_i(pend), .any_o(pend_any), .idx_o(win_idx), .oh_o(win_oh)
  );

  pvic_prio #(.NUM_IRQ(NUM_IRQ)) i_prio_isr (
    .vec_i(isr_q), .any_o(isr_any), .idx_o(isr_idx), .oh_o(isr_oh)
  );

  assign int_o  = ready && pend_any && (!isr_any || (win_idx < isr_idx));
  assign grant  = inta_i && int_o;
  assign ack_oh = grant ? win_oh : '0;

  always_comb begin
    isr_d = isr_q | ack_oh;
    if (eoi.ns) isr_d = isr_d & ~isr_oh;
    if (eoi.sp) isr_d[eoi.lvl] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    isr_q <= '0;
    else if (start) isr_q <= '0;
    else            isr_q <= isr_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vector_o     <= '0;
      vector_vld_o <= 1'b0;
    end else begin
      vector_vld_o <= inta_i;
      if (inta_i) vector_o <= {base, grant ? win_idx : {LVL_W{1'b1}}};
    end
  end

  assign rdata_o   = addr_i ? imr : (rd_isr ? isr_q : irr);
  assign cascade_o = ready && !single;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned LVL_W  = $clog2(NUM_IRQ)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               int_o,
  input logic               inta_i,
  input logic               vector_vld_o,
  input logic               ready,
  input logic               start,
  input logic [NUM_IRQ-1:0] isr_q,
  input logic [NUM_IRQ-1:0] win_oh,
  input logic [LVL_W-1:0]   win_idx,
  input logic [LVL_W-1:0]   isr_idx,
  input logic               isr_any,
  input logic               eoi_ns
);
  assert_int_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ready);

  assert_nested_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && isr_any) |-> (win_idx < isr_idx));

  assert_grant_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_oh));

  assert_vld_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_vld_o |-> $past(inta_i));

  assert_ack_sets_isr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !start) |=> isr_q[$past(win_idx)]);

  assert_ns_eoi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_ns && isr_any && !(inta_i && int_o)) |=> !isr_q[$past(isr_idx)]);
endmodule

bind pvic_top pvic_chk #(.NUM_IRQ(NUM_IRQ)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .int_o(int_o), .inta_i(inta_i),
  .vector_vld_o(vector_vld_o), .ready(ready), .start(start), .isr_q(isr_q),
  .win_oh(win_oh), .win_idx(win_idx), .isr_idx(isr_idx), .isr_any(isr_any),
  .eoi_ns(eoi.ns)
);

// File: tb/test_pvic_top.sv
module test_pvic_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] irq_i = '0;
  logic       int_o;
  logic       inta_i = 1'b0;
  logic [7:0] vector_o;
  logic       vector_vld_o;
  logic       cascade_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pvic_top i_pvic_top (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr_i = a; #0.1 d = rdata_o; addr_i = 1'b0;
  endtask

  task automatic set_irq(input int l, input logic v);
    @(negedge clk_i);
    irq_i[l] = v;
    @(negedge clk_i);
  endtask

  task automatic ack();
    @(negedge clk_i);
    inta_i = 1'b1;
    @(negedge clk_i);
    inta_i = 1'b0;
  endtask

  task automatic init_single(input logic [7:0] w1, input logic [7:0] base);
    wr(1'b0, w1); wr(1'b1, base); wr(1'b1, 8'h01);
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset int", int_o, 0);
    chk("R6 reset vld", vector_vld_o, 0);
    chk("R2 reset cascade", cascade_o, 0);
    rd(1'b1, r); chk("R3 reset mask", r, 0);

    // R1: no interrupt before init
    set_irq(0, 1'b1);
    chk("R1 pre-init int", int_o, 0);
    wr(1'b0, 8'h20);
    chk("R1 pre-init int after ctl", int_o, 0);
    set_irq(0, 1'b0);

    // R2: cascade path with ICW3 and ICW4
    wr(1'b0, 8'h11); wr(1'b1, 8'h40);
    chk("R2 mid-seq cascade", cascade_o, 0);
    wr(1'b1, 8'h04);
    chk("R2 before mode word", cascade_o, 0);
    wr(1'b1, 8'h01);
    chk("R2 cascade flag", cascade_o, 1);
    rd(1'b1, r); chk("R2 seq words not mask", r, 0);

    // R2: restart mid-sequence, then single mode
    wr(1'b0, 8'h13); wr(1'b1, 8'h50);
    init_single(8'h13, 8'hA8);
    chk("R2 single flag", cascade_o, 0);
    rd(1'b1, r); chk("R2 mask after seq", r, 0);

    // sweep all levels
    for (int l = 0; l < 8; l++) begin
      set_irq(l, 1'b1);
      chk("R4 int on request", int_o, 1);
      rd(1'b0, r); chk("R10 irr read", r, 1 << l);
      ack();
      chk("R6 vld", vector_vld_o, 1);
      chk("R6 vector", vector_o, 8'hA8 | l);
      chk("R4 int blocked by own isr", int_o, 0);
      wr(1'b0, 8'h0B);
      rd(1'b0, r); chk("R6 isr set", r, 1 << l);
      wr(1'b0, 8'h20);
      rd(1'b0, r); chk("R7 isr cleared", r, 0);
      wr(1'b0, 8'h0A);
      rd(1'b0, r); chk("R9 irr no relatch while high", r, 0);
      chk("R9 int quiet while high", int_o, 0);
      set_irq(l, 1'b0);
    end

    // nesting
    set_irq(5, 1'b1); ack();
    chk("R6 vector 5", vector_o, 8'hAD);
    set_irq(6, 1'b1);
    chk("R4 lower blocked", int_o, 0);
    set_irq(2, 1'b1);
    chk("R4 higher preempts", int_o, 1);
    ack();
    chk("R6 vector 2", vector_o, 8'hAA);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R6 nested isr", r, 8'h24);
    wr(1'b0, 8'h20);
    rd(1'b0, r); chk("R7 ns eoi highest", r, 8'h20);
    chk("R4 still blocked by 5", int_o, 0);
    wr(1'b0, 8'h65);
    rd(1'b0, r); chk("R8 specific eoi", r, 0);
    chk("R4 six released", int_o, 1);
    ack();
    chk("R6 vector 6", vector_o, 8'hAE);
    wr(1'b0, 8'h66);
    rd(1'b0, r); chk("R8 specific eoi 6", r, 0);
    wr(1'b0, 8'h0A);
    irq_i = '0;
    @(negedge clk_i);

    // R9: re-edge relatches
    set_irq(3, 1'b1); ack(); wr(1'b0, 8'h20);
    chk("R9 held high no int", int_o, 0);
    set_irq(3, 1'b0);
    set_irq(3, 1'b1);
    chk("R9 new edge int", int_o, 1);
    ack(); wr(1'b0, 8'h20); set_irq(3, 1'b0);

    // R3: mask
    wr(1'b1, 8'h10);
    set_irq(4, 1'b1);
    chk("R3 masked no int", int_o, 0);
    rd(1'b0, r); chk("R3 masked still recorded", r, 8'h10);
    rd(1'b1, r); chk("R3 mask readback", r, 8'h10);
    wr(1'b1, 8'h00);
    chk("R3 unmask int", int_o, 1);
    ack();
    chk("R6 vector 4", vector_o, 8'hAC);
    wr(1'b0, 8'h20); set_irq(4, 1'b0);

    // R6: acknowledge with no request
    ack();
    chk("R6 spurious vld", vector_vld_o, 1);
    chk("R6 spurious vector", vector_o, 8'hAF);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R6 spurious no isr", r, 0);

    // R10: reinit clears state, then level mode
    set_irq(7, 1'b1); ack();
    rd(1'b0, r); chk("R10 isr before reinit", r, 8'h80);
    wr(1'b1, 8'hFF);
    set_irq(7, 1'b0);
    init_single(8'h1B, 8'hA8);
    rd(1'b1, r); chk("R10 mask cleared", r, 0);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R10 isr cleared", r, 0);
    wr(1'b0, 8'h0A);
    set_irq(1, 1'b1);
    rd(1'b0, r); chk("R5 level latched", r, 8'h02);
    chk("R5 level int", int_o, 1);
    set_irq(1, 1'b0);
    rd(1'b0, r); chk("R5 level withdrawn", r, 0);
    chk("R5 level int drop", int_o, 0);
    set_irq(1, 1'b1); ack();
    chk("R6 level vector", vector_o, 8'hA9);
    wr(1'b0, 8'h20);
    rd(1'b0, r); chk("R5 level relatch", r, 8'h02);
    chk("R5 level int again", int_o, 1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
    $finish;
  end
endmodule